// File: doc/BRIEF.md
# Block-transfer bus slot sequencer

This block decides, cycle by cycle, which bus slot a block-transfer engine uses. The engine has three source channels, A, B and C, which read words from memory, and one destination channel, D, which writes the combined result back. A 4-bit code chooses the active channels. A 16-bit word count sets the length of the transfer. After a start pulse the block produces one slot per granted cycle. A slot is a source fetch, a destination write or an idle slot. Each real slot carries its channel and its word index.

The destination write trails the fetches by one word, because the result path inside the engine is pipelined. Every source is therefore read twice before the first write can go out. Idle slots are placed according to the active channel set. A low bus grant freezes the sequence, so other traffic can take the bus without the slot order changing.

Address generation, data shifting, masking, fill and the logic function are handled elsewhere. A downstream address unit uses the channel tag and the word index from this block.

Top module: `blit_slot_seq`

## Requirements
- R1: The channel code maps bit 3 to A, bit 2 to B, bit 1 to C and bit 0 to D. A code of zero produces no slot, and done pulses in the cycle after start.
- R2: A word count of zero produces no slot. Done pulses in the cycle after start and busy stays low.
- R3: Within a word, the enabled sources are fetched in the order A, B, C, and disabled channels are skipped. The channel tags are A=0, B=1, C=2 and D=3, and slot_word_index gives the word being fetched.
- R4: When D and at least one source are enabled, each word's fetches are followed by a D slot. For word 0 this slot is idle. For word n≥1 it writes result n-1. After the last word there is one idle slot and then the final write.
- R5: With only D enabled, the stream is D0, idle, D1, idle, ..., ending with the last write and no trailing idle slot.
- R6: With D disabled, one idle slot separates consecutive words when exactly one source is enabled, or when only A and B are enabled, or when only B and C are enabled. A with C, and A with B and C, run with no idle slot.
- R7: When D is enabled, A is disabled and B or C is enabled, one further idle slot comes before the fetches of each word from word 2 onward.
- R8: While bus_grant is low, no slot is consumed and slot_valid is low. slot_chan, slot_is_write and slot_word_index keep their values.
- R9: busy rises in the cycle after an accepted start and falls after the last slot. done is a one-cycle pulse in the cycle after the last slot, and done is never high together with busy.
- R10: A start pulse that arrives while busy is high is ignored. The running transfer continues with its own code and count.
- R11: slot_is_write is high on a valid slot exactly when the slot belongs to channel D. Fetch slots carry slot_is_write low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin a transfer |
| chan_code | input | 4 | Active channels: bit 3 A, bit 2 B, bit 1 C, bit 0 D |
| word_count | input | 16 | Number of words in the transfer |
| bus_grant | input | 1 | High when the engine owns the bus this cycle |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse after the last slot |
| slot_valid | output | 1 | A real fetch or write occupies this granted cycle |
| slot_chan | output | 2 | Channel of the slot (A=0, B=1, C=2, D=3) |
| slot_is_write | output | 1 | Slot is a destination write |
| slot_word_index | output | 16 | Word number the slot belongs to |

## Verification
All sixteen channel codes are run at lengths of 1, 2, 3 and 5 words. These lengths separate the first-word idle D slot, the extra gap that starts only at word 2, and the tail idle slot followed by the last write. Each code is run twice: once with full grant, and once with grant dropped at random. The second run shows that stalls leave the order unchanged and never let a slot through unseen. Directed cases cover the literal four-channel three-word stream, a zero count, a start pulse during a transfer, and a long grant hold-off right after start.

// File: rtl/blit_slot_pkg.sv
package blit_slot_pkg;
   localparam int unsigned CHAN_W = 2;
   localparam int unsigned NSRC   = 3;
   localparam logic [CHAN_W-1:0] CH_A = 2'd0;
   localparam logic [CHAN_W-1:0] CH_B = 2'd1;
   localparam logic [CHAN_W-1:0] CH_C = 2'd2;
   localparam logic [CHAN_W-1:0] CH_D = 2'd3;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_GAP,
      ST_FETCH,
      ST_DSLOT,
      ST_DONLY,
      ST_TAIL_GAP,
      ST_TAIL_D
   } seq_state_e;
endpackage

// File: rtl/blit_slot_pick.sv
// Picks the lowest-numbered enabled source, either from the top of the
// list or strictly after a given channel.
module blit_slot_pick #(
   parameter int unsigned NSRC = 3,
   parameter int unsigned CW   = 2
) (
   input  logic [NSRC-1:0] en,
   input  logic [CW-1:0]   after,
   input  logic            from_top,
   output logic            found,
   output logic [CW-1:0]   pick
);
   logic [NSRC-1:0] cand;

   generate
      if (NSRC > (1 << CW)) begin : g_bad_width
         $error("blit_slot_pick: channel field too narrow");
      end
      for (genvar i = 0; i < NSRC; i++) begin : g_cand
         assign cand[i] = en[i] && (from_top || (CW'(i) > after));
      end
   endgenerate

   always_comb begin
      found = 1'b0;
      pick  = '0;
      for (int i = NSRC - 1; i >= 0; i--) begin
         if (cand[i]) begin
            found = 1'b1;
            pick  = CW'(i);
         end
      end
   end
endmodule

// File: rtl/blit_slot_mode.sv
// Decodes the channel code into source enables and idle-gap rules.
module blit_slot_mode #(
   parameter int unsigned NSRC = 3
) (
   input  logic [NSRC:0]   code,
   output logic [NSRC-1:0] src_en,
   output logic            has_d,
   output logic            has_src,
   output logic            d_only,
   output logic            gap_from1,
   output logic            gap_from2
);
   localparam int unsigned CNT_W = $clog2(NSRC + 1);
   logic [CNT_W-1:0] n_src;
   logic             pair_gap;

   generate
      for (genvar i = 0; i < NSRC; i++) begin : g_map
         // source index 0 is the highest code bit
         assign src_en[i] = code[NSRC - i];
      end
   endgenerate

   always_comb begin
      n_src = '0;
      for (int i = 0; i < NSRC; i++) n_src = n_src + CNT_W'(src_en[i]);
   end

   assign has_d    = code[0];
   assign has_src  = |src_en;
   assign d_only   = has_d && !has_src;
   // A+B only or B+C only (index 0=A, 1=B, 2=C)
   assign pair_gap = (src_en == NSRC'(3'b011)) || (src_en == NSRC'(3'b110));

   assign gap_from1 = d_only ||
                      (!has_d && ((n_src == CNT_W'(1)) || pair_gap));
   assign gap_from2 = has_d && has_src && !src_en[0];
endmodule

// File: rtl/blit_slot_seq.sv
module blit_slot_seq
   import blit_slot_pkg::*;
#(
   parameter int unsigned WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [3:0]        chan_code,
   input  logic [WORD_W-1:0] word_count,
   input  logic              bus_grant,
   output logic              busy,
   output logic              done,
   output logic              slot_valid,
   output logic [1:0]        slot_chan,
   output logic              slot_is_write,
   output logic [WORD_W-1:0] slot_word_index
);
   generate
      if (WORD_W < 2) begin : g_bad_word
         $error("blit_slot_seq: WORD_W must be at least 2");
      end
   endgenerate

   seq_state_e        st_q, st_n;
   logic [3:0]        cfg_q, cfg_sel;
   logic [WORD_W-1:0] word_q, word_n, last_q;
   logic [CHAN_W-1:0] ch_q, ch_n;
   logic              done_q, done_n;

   logic [NSRC-1:0]   src_en;
   logic              has_d, has_src, d_only, gap_from1, gap_from2;
   logic              first_found, next_found;
   logic [CHAN_W-1:0] first_ch, next_ch;
   logic              adv, word_end, finish, accept, empty_req;
   logic [WORD_W-1:0] word_inc;
   logic              gap_next;

   assign cfg_sel = (st_q == ST_IDLE) ? chan_code : cfg_q;

   blit_slot_mode #(.NSRC(NSRC)) u_mode (
      .code      (cfg_sel),
      .src_en    (src_en),
      .has_d     (has_d),
      .has_src   (has_src),
      .d_only    (d_only),
      .gap_from1 (gap_from1),
      .gap_from2 (gap_from2)
   );

   blit_slot_pick #(.NSRC(NSRC), .CW(CHAN_W)) u_first (
      .en       (src_en),
      .after    ('0),
      .from_top (1'b1),
      .found    (first_found),
      .pick     (first_ch)
   );

   blit_slot_pick #(.NSRC(NSRC), .CW(CHAN_W)) u_next (
      .en       (src_en),
      .after    (ch_q),
      .from_top (1'b0),
      .found    (next_found),
      .pick     (next_ch)
   );

   assign busy      = (st_q != ST_IDLE);
   assign adv       = busy && bus_grant;
   assign empty_req = (chan_code == 4'd0) || (word_count == '0);
   assign accept    = (st_q == ST_IDLE) && start && !empty_req;
   assign word_inc  = word_q + WORD_W'(1);
   assign gap_next  = (gap_from1 && (word_inc != '0)) ||
                      (gap_from2 && (word_inc >= WORD_W'(2)));

   always_comb begin
      st_n     = st_q;
      ch_n     = ch_q;
      word_n   = word_q;
      word_end = 1'b0;
      finish   = 1'b0;
      unique case (st_q)
         ST_IDLE: begin
            if (accept) begin
               word_n = '0;
               st_n   = has_src ? ST_FETCH : ST_DONLY;
               ch_n   = first_ch;
            end
         end
         ST_GAP: begin
            if (adv) begin
               st_n = has_src ? ST_FETCH : ST_DONLY;
               ch_n = first_ch;
            end
         end
         ST_FETCH: begin
            if (adv) begin
               if (next_found)  ch_n = next_ch;
               else if (has_d)  st_n = ST_DSLOT;
               else             word_end = 1'b1;
            end
         end
         ST_DSLOT, ST_DONLY: begin
            if (adv) word_end = 1'b1;
         end
         ST_TAIL_GAP: begin
            if (adv) st_n = ST_TAIL_D;
         end
         ST_TAIL_D: begin
            if (adv) finish = 1'b1;
         end
         default: st_n = ST_IDLE;
      endcase

      if (word_end) begin
         if (word_q == last_q) begin
            if (has_d && has_src) st_n = ST_TAIL_GAP;
            else                  finish = 1'b1;
         end else begin
            word_n = word_inc;
            if (gap_next) begin
               st_n = ST_GAP;
            end else begin
               st_n = has_src ? ST_FETCH : ST_DONLY;
               ch_n = first_ch;
            end
         end
      end
      if (finish) st_n = ST_IDLE;
   end

   assign done_n = finish || ((st_q == ST_IDLE) && start && empty_req);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         cfg_q  <= '0;
         word_q <= '0;
         last_q <= '0;
         ch_q   <= CH_A;
         done_q <= 1'b0;
      end else begin
         st_q   <= st_n;
         word_q <= word_n;
         ch_q   <= ch_n;
         done_q <= done_n;
         if (accept) begin
            cfg_q  <= chan_code;
            last_q <= word_count - WORD_W'(1);
         end
      end
   end

   assign done            = done_q;
   assign slot_chan       = (st_q == ST_FETCH) ? ch_q : CH_D;
   assign slot_is_write   = (st_q == ST_DSLOT) || (st_q == ST_DONLY) ||
                            (st_q == ST_TAIL_D);
   assign slot_word_index = (st_q == ST_DSLOT) ? (word_q - WORD_W'(1)) : word_q;
   assign slot_valid      = adv && ((st_q == ST_FETCH) || (st_q == ST_DONLY) ||
                                    (st_q == ST_TAIL_D) ||
                                    ((st_q == ST_DSLOT) && (word_q != '0)));
endmodule

// File: rtl/blit_slot_seq_chk.sv
module blit_slot_seq_chk #(
   parameter int unsigned WORD_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              bus_grant,
   input logic              busy,
   input logic              done,
   input logic              slot_valid,
   input logic [1:0]        slot_chan,
   input logic              slot_is_write,
   input logic [WORD_W-1:0] slot_word_index
);
   // R8: a real slot only in a granted, busy cycle
   p_valid_granted_r8: assert property (@(posedge clk) disable iff (!rst_n)
      slot_valid |-> (bus_grant && busy));

   // R8: a stalled cycle keeps the slot tag unchanged
   p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !bus_grant) |=> (busy && $stable(slot_chan) &&
                                $stable(slot_word_index) && $stable(slot_is_write)));

   // R9: done never overlaps busy
   p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   // R9: busy only ends with a done pulse
   p_busy_ends_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> (busy || done));

   // R10: a start during a transfer does not end it
   p_start_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start && !bus_grant) |=> busy);

   // R11: writes belong to channel D
   p_write_is_d_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_valid && slot_is_write) |-> (slot_chan == 2'd3));

   // R11: source channels never write
   p_fetch_reads_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_valid && (slot_chan != 2'd3)) |-> !slot_is_write);
endmodule

bind blit_slot_seq blit_slot_seq_chk #(.WORD_W(WORD_W)) u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .start           (start),
   .bus_grant       (bus_grant),
   .busy            (busy),
   .done            (done),
   .slot_valid      (slot_valid),
   .slot_chan       (slot_chan),
   .slot_is_write   (slot_is_write),
   .slot_word_index (slot_word_index)
);

// File: tb/blit_slot_seq_test.sv
`timescale 1ns/1ps
module blit_slot_seq_test;
   localparam int IDLE_TOK = -1;
   localparam int unsigned NCNT = 4;
   localparam int unsigned CNT_TAB [NCNT] = '{1, 2, 3, 5};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [3:0]  chan_code = 4'd0;
   logic [15:0] word_count = 16'd0;
   logic        bus_grant = 1'b1;
   logic        busy, done, slot_valid, slot_is_write;
   logic [1:0]  slot_chan;
   logic [15:0] slot_word_index;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   blit_slot_seq uut (
      .clk(clk), .rst_n(rst_n), .start(start), .chan_code(chan_code),
      .word_count(word_count), .bus_grant(bus_grant), .busy(busy),
      .done(done), .slot_valid(slot_valid), .slot_chan(slot_chan),
      .slot_is_write(slot_is_write), .slot_word_index(slot_word_index)
   );

   function automatic int tok_fetch(int ch, int w);
      return (ch << 16) | w;
   endfunction
   function automatic int tok_write(int w);
      return (1 << 18) | (3 << 16) | w;
   endfunction

   task automatic chk(bit ok, string req, string what, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // Expected stream, written from R3..R7 and R11
   function automatic void gen(logic [3:0] code, int n, ref int q[$]);
      bit a, b, c, d, g1, g2;
      int ns;
      q.delete();
      a = code[3]; b = code[2]; c = code[1]; d = code[0];
      ns = int'(a) + int'(b) + int'(c);
      if (code == 4'd0 || n == 0) return;
      if (ns == 0) begin                         // R5
         for (int w = 0; w < n; w++) begin
            if (w > 0) q.push_back(IDLE_TOK);
            q.push_back(tok_write(w));
         end
         return;
      end
      g1 = !d && (ns == 1 || (a && b && !c) || (!a && b && c));  // R6
      g2 = d && !a;                                                // R7
      for (int w = 0; w < n; w++) begin
         if ((g1 && w >= 1) || (g2 && w >= 2)) q.push_back(IDLE_TOK);
         if (a) q.push_back(tok_fetch(0, w));                       // R3
         if (b) q.push_back(tok_fetch(1, w));
         if (c) q.push_back(tok_fetch(2, w));
         if (d) q.push_back(w == 0 ? IDLE_TOK : tok_write(w - 1)); // R4
      end
      if (d) begin
         q.push_back(IDLE_TOK);
         q.push_back(tok_write(n - 1));
      end
   endfunction

   function automatic string req_of(logic [3:0] code);
      if (code == 4'd0) return "R1";
      if (code == 4'd1) return "R5";
      if (code[0] && !code[3]) return "R7/R4/R3";
      if (code[0]) return "R4/R3";
      return "R6/R3";
   endfunction

   task automatic run_one(input logic [3:0] code, input int n, input bit stall,
                          input int hold, input bit restart_mid,
                          input string req, ref int exp_q[$]);
      int got_q[$];
      int dn = 0;
      int cyc = 0;
      int bad_hold = 0;
      int first_bad = -1;
      @(negedge clk);
      chan_code = code; word_count = n[15:0]; start = 1'b1; bus_grant = 1'b1;
      @(negedge clk);
      while (cyc < 3000) begin
         start = 1'b0;
         if (restart_mid && cyc == 3) begin
            start = 1'b1; chan_code = ~code; word_count = 16'd7;  // R10
         end
         if (cyc < hold) bus_grant = 1'b0;
         else if (stall) bus_grant = ($urandom_range(0, 3) != 0);
         else bus_grant = 1'b1;
         #1;
         if (!bus_grant && slot_valid) bad_hold++;
         if (busy && bus_grant)
            got_q.push_back(slot_valid ?
               int'({13'd0, slot_is_write, slot_chan, slot_word_index}) : IDLE_TOK);
         if (done) begin dn++; break; end
         @(negedge clk);
         cyc++;
      end
      start = 1'b0;
      bus_grant = 1'b1;
      for (int i = 0; i < got_q.size() && i < exp_q.size(); i++)
         if (first_bad < 0 && got_q[i] != exp_q[i]) first_bad = i;
      chk(got_q.size() == exp_q.size(), req, $sformatf("slot count code=%0h n=%0d", code, n),
          got_q.size(), exp_q.size());
      if (first_bad >= 0)
         chk(1'b0, req, $sformatf("slot %0d code=%0h n=%0d", first_bad, code, n),
             got_q[first_bad], exp_q[first_bad]);
      else
         chk(1'b1, req, "slot order", 0, 0);
      chk(dn == 1, "R9", $sformatf("done seen code=%0h n=%0d", code, n), dn, 1);
      if (stall || hold > 0)
         chk(bad_hold == 0, "R8", "valid while grant low", bad_hold, 0);
      @(negedge clk); #1;
      chk(!done && !busy, "R9", "done is one cycle", int'({done, busy}), 0);
   endtask

   initial begin
      #(4 * 150000);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      int exp_q[$];
      repeat (3) @(negedge clk);
      #1;
      chk(!busy && !done && !slot_valid, "R9", "reset state",
          int'({busy, done, slot_valid}), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // table walk: every code, every length, steady and stalled grant
      for (int k = 0; k < 16 * NCNT; k++) begin
         logic [3:0] code;
         int n;
         code = k[5:2];
         n = int'(CNT_TAB[k % NCNT]);
         gen(code, n, exp_q);
         run_one(code, n, 1'b0, 0, 1'b0, req_of(code), exp_q);
         run_one(code, n, 1'b1, 0, 1'b0, req_of(code), exp_q);
      end

      // R4/R3/R11: literal four-channel, three-word stream
      exp_q = '{tok_fetch(0,0), tok_fetch(1,0), tok_fetch(2,0), IDLE_TOK,
                tok_fetch(0,1), tok_fetch(1,1), tok_fetch(2,1), tok_write(0),
                tok_fetch(0,2), tok_fetch(1,2), tok_fetch(2,2), tok_write(1),
                IDLE_TOK, tok_write(2)};
      run_one(4'hF, 3, 1'b0, 0, 1'b0, "R4", exp_q);

      // R2: zero count gives no slot
      exp_q.delete();
      run_one(4'hF, 0, 1'b0, 0, 1'b0, "R2", exp_q);

      // R1: code zero with a nonzero count
      run_one(4'h0, 4, 1'b0, 0, 1'b0, "R1", exp_q);

      // R10: start during a transfer is ignored
      gen(4'hB, 5, exp_q);
      run_one(4'hB, 5, 1'b0, 0, 1'b1, "R10", exp_q);

      // R8: long hold-off right after start
      gen(4'h7, 3, exp_q);
      run_one(4'h7, 3, 1'b0, 6, 1'b0, "R8", exp_q);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule